// File: doc/BRIEF.md
# Clock Fan-Out Output Enable Controller

This block works out, for each of the twenty outputs of a clock fan-out buffer, whether the output drives and whether it sits in tri-state. A channel's enable can come from one of two paths. The first path combines a register of enable bits, which an external SMBus engine writes, with active-low enable pins on channels 5 through 12. The second path is a three-wire serial side-band link that shifts a full enable word in and then commits it. A select input chooses the path. Three of the enable pins carry the side-band data, clock and load signals when the side-band path is selected.

A power-good input starts the device. Its first rising edge captures the two three-level address straps as a single code and leaves the pre-start state. After that edge the same input is an active-low power-down: while it is low, every channel is in tri-state. All asynchronous inputs pass through two-flop synchronisers, and edges are detected on the synchronised copies.

Top module: `clkoe_ctrl`

## Requirements
- R1: After reset, `chanHiZ` is all ones, `chanEn` is all zeros, `started` is 0 and `addrCode` is 0.
- R2: Until the first rising edge of `pwrGood`, every channel is tri-stated and disabled, whatever the other inputs are.
- R3: The first rising edge of `pwrGood` sets `started`, which then stays 1. The same edge latches `addrCode = 3*hi + lo`, where each strap is encoded as low=2'b00→0, mid=2'b01→1, high=2'b10→2, and 2'b11 is read as mid. Later changes to the straps or to `pwrGood` leave the code unchanged.
- R4: Once started, `pwrGood` low forces `chanHiZ` to all ones and `chanEn` to zero. `pwrGood` high restores normal operation.
- R5: With `sbSel` low, channel c in 5..12 is enabled only when enable-register bit c is 1 and `pinOeN[c-5]` is 0.
- R6: With `sbSel` low, channels 0..4 and 13..19 follow their enable-register bit alone.
- R7: The enable register resets to all ones, and a cycle with `regWr` high loads it from `regWrData`.
- R8: With `sbSel` high, `chanEn` equals the side-band output register. The enable pins and the enable register are ignored.
- R9: In side-band mode, `pinOeN[0]` is data, `pinOeN[1]` is clock and `pinOeN[5]` is load. Each rising clock edge while load is high shifts the data bit into bit 0, moving the older bits toward bit 19. After twenty shifts, the first bit sent drives channel 19.
- R10: A falling edge on load copies the shift register into the output register. Clock edges while load is low change nothing.
- R11: When a clock rise and a load fall reach the synchronised domain in the same cycle, no shift occurs and the output register receives the contents from before that cycle.
- R12: With `sbSel` low, activity on the three shared pins neither shifts nor loads the side-band registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwrGood | input | 1 | Power-good on first rise, then active-low power-down |
| sbSel | input | 1 | 1 selects the side-band path, 0 selects the pin/register path |
| pinOeN | input | 8 | Active-low enables for channels 5..12; bits 0, 1 and 5 are shared with side-band data, clock and load |
| strapLo | input | 2 | Low-order address strap level |
| strapHi | input | 2 | High-order address strap level |
| regWr | input | 1 | Write strobe for the enable register |
| regWrData | input | 20 | New enable register value |
| chanEn | output | 20 | Per-channel enable |
| chanHiZ | output | 20 | Per-channel tri-state control |
| started | output | 1 | First power-good edge has been seen |
| addrCode | output | 4 | Latched strap code, 0..8 |

## Verification
The side-band clock and the load line can both change in the same synchronised cycle. In that cycle, a shift and a transfer to the output register compete. The bench provokes this by driving the clock pin high and the load pin low at the same falling edge, after first shifting a few known bits into a known word. The result is judged from `chanEn`: it must show the word as it stood before that clock edge, neither shifted once more nor left at its older committed value.

// File: rtl/clkoe_pkg.sv
package clkoe_pkg;
  // positions of the shared side-band wires inside the dedicated pin vector
  localparam int DataPinIdx = 0;
  localparam int ClkPinIdx  = 1;
  localparam int LoadPinIdx = 5;

  typedef struct packed {
    logic sbMode;    // side-band path selected (synchronised)
    logic shiftStb;  // shift one bit this cycle
    logic loadStb;   // commit shift register this cycle
    logic sbBit;     // serial data bit
    logic outHiZ;    // force all channels to tri-state
  } oeStrobeT;

  typedef enum logic [1:0] {
    STRAP_LOW  = 2'b00,
    STRAP_MID  = 2'b01,
    STRAP_HIGH = 2'b10
  } strapLvlT;

  function automatic logic [3:0] strapDigit(input logic [1:0] lvl);
    case (lvl)
      STRAP_LOW:  strapDigit = 4'd0;
      STRAP_HIGH: strapDigit = 4'd2;
      default:    strapDigit = 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/clkoe_sync.sv
module clkoe_sync #(
  parameter int Width  = 1,
  parameter int Stages = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] asyncIn,
  output logic [Width-1:0] syncOut
);
  logic [Width-1:0] chain [Stages];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < Stages; s++) chain[s] <= '0;
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < Stages; s++) chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[Stages-1];
endmodule

// File: rtl/clkoe_ctl.sv
module clkoe_ctl
  import clkoe_pkg::*;
#(
  parameter int NumPins    = 8,
  parameter int SyncStages = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwrGood,
  input  logic               sbSel,
  input  logic [NumPins-1:0] pinOeN,
  input  logic [1:0]         strapLo,
  input  logic [1:0]         strapHi,
  output oeStrobeT           stb,
  output logic [NumPins-1:0] pinSync,
  output logic               started,
  output logic [3:0]         addrCode
);
  localparam int SyncW = NumPins + 2;

  logic [SyncW-1:0] rawIn, syncd;
  logic pgS, selS, clkS, loadS;
  logic clkPrev, loadPrev, pgPrev;
  logic pgRise;

  assign rawIn = {pwrGood, sbSel, pinOeN};

  clkoe_sync #(.Width(SyncW), .Stages(SyncStages)) inSync (
    .clk(clk), .rstN(rstN), .asyncIn(rawIn), .syncOut(syncd)
  );

  assign pinSync = syncd[NumPins-1:0];
  assign selS    = syncd[NumPins];
  assign pgS     = syncd[NumPins+1];
  assign clkS    = pinSync[ClkPinIdx];
  assign loadS   = pinSync[LoadPinIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      loadPrev <= 1'b0;
      pgPrev   <= 1'b0;
    end else begin
      clkPrev  <= clkS;
      loadPrev <= loadS;
      pgPrev   <= pgS;
    end
  end

  assign pgRise = pgS & ~pgPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started  <= 1'b0;
      addrCode <= '0;
    end else if (pgRise && !started) begin
      started  <= 1'b1;
      addrCode <= 4'd3 * strapDigit(strapHi) + strapDigit(strapLo);
    end
  end

  // shifting needs load high now; a falling load means it is low now
  always_comb begin
    stb.sbMode   = selS;
    stb.shiftStb = selS & loadS & clkS & ~clkPrev;
    stb.loadStb  = selS & ~loadS & loadPrev;
    stb.sbBit    = pinSync[DataPinIdx];
    stb.outHiZ   = ~started | ~pgS;
  end

  // R3
  started_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    started |=> started);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(started)) |-> $stable(addrCode));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.shiftStb && stb.loadStb));
endmodule

// File: rtl/clkoe_dp.sv
module clkoe_dp
  import clkoe_pkg::*;
#(
  parameter int NumCh   = 20,
  parameter int PinBase = 5,
  parameter int NumPins = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  oeStrobeT           stb,
  input  logic [NumPins-1:0] pinSync,
  input  logic               regWr,
  input  logic [NumCh-1:0]   regWrData,
  output logic [NumCh-1:0]   chanEn,
  output logic [NumCh-1:0]   chanHiZ
);
  logic [NumCh-1:0] regBits, shiftReg, sbOut, pinOk, pathEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regBits <= '1;
    else if (regWr) regBits <= regWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sbOut    <= '0;
    end else begin
      if (stb.shiftStb) shiftReg <= {shiftReg[NumCh-2:0], stb.sbBit};
      if (stb.loadStb)  sbOut    <= shiftReg;
    end
  end

  for (genvar ch = 0; ch < NumCh; ch++) begin : g_pin
    if (ch >= PinBase && ch < PinBase + NumPins) begin : g_has
      assign pinOk[ch] = ~pinSync[ch-PinBase];
    end else begin : g_none
      assign pinOk[ch] = 1'b1;
    end
  end

  assign pathEn  = stb.sbMode ? sbOut : (regBits & pinOk);
  assign chanHiZ = {NumCh{stb.outHiZ}};
  assign chanEn  = stb.outHiZ ? '0 : pathEn;

  // R9
  shift_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftStb |=> shiftReg == {$past(shiftReg[NumCh-2:0]), $past(stb.sbBit)});

  // R10
  load_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadStb |=> sbOut == $past(shiftReg));

  // R4
  hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|chanHiZ) |-> (chanEn == '0));
endmodule

// File: rtl/clkoe_ctrl.sv
module clkoe_ctrl
  import clkoe_pkg::*;
#(
  parameter int NumCh      = 20,
  parameter int PinBase    = 5,
  parameter int NumPins    = 8,
  parameter int SyncStages = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwrGood,
  input  logic               sbSel,
  input  logic [NumPins-1:0] pinOeN,
  input  logic [1:0]         strapLo,
  input  logic [1:0]         strapHi,
  input  logic               regWr,
  input  logic [NumCh-1:0]   regWrData,
  output logic [NumCh-1:0]   chanEn,
  output logic [NumCh-1:0]   chanHiZ,
  output logic               started,
  output logic [3:0]         addrCode
);
  oeStrobeT           stb;
  logic [NumPins-1:0] pinSync;

  clkoe_ctl #(.NumPins(NumPins), .SyncStages(SyncStages)) ctl (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .sbSel(sbSel),
    .pinOeN(pinOeN), .strapLo(strapLo), .strapHi(strapHi),
    .stb(stb), .pinSync(pinSync), .started(started), .addrCode(addrCode)
  );

  clkoe_dp #(.NumCh(NumCh), .PinBase(PinBase), .NumPins(NumPins)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pinSync(pinSync),
    .regWr(regWr), .regWrData(regWrData),
    .chanEn(chanEn), .chanHiZ(chanHiZ)
  );
endmodule

// File: tb/clkoe_ctrl_test.sv
`timescale 1ns/1ps
module clkoe_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pwrGood = 1'b0;
  logic        sbSel = 1'b0;
  logic [7:0]  pins = 8'h00;
  logic [1:0]  strapLo = 2'b00, strapHi = 2'b00;
  logic        regWr = 1'b0;
  logic [19:0] regWrData = '0;
  logic [19:0] chanEn, chanHiZ;
  logic        started;
  logic [3:0]  addrCode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clkoe_ctrl uut (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .sbSel(sbSel), .pinOeN(pins),
    .strapLo(strapLo), .strapHi(strapHi), .regWr(regWr), .regWrData(regWrData),
    .chanEn(chanEn), .chanHiZ(chanHiZ), .started(started), .addrCode(addrCode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [19:0] expPin(input logic [19:0] r, input logic [7:0] p);
    logic [19:0] e;
    for (int ch = 0; ch < 20; ch++)
      e[ch] = (ch >= 5 && ch <= 12) ? (r[ch] & ~p[ch-5]) : r[ch];
    return e;
  endfunction

  task automatic writeReg(input logic [19:0] v);
    regWrData = v;
    regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic sbClockBit(input logic b);
    pins[0] = b;   settle();
    pins[1] = 1'b1; settle();
    pins[1] = 1'b0; settle();
  endtask

  task automatic sbWrite(input logic [19:0] w);
    pins[5] = 1'b1; settle();
    for (int i = 19; i >= 0; i--) sbClockBit(w[i]);
    pins[5] = 1'b0; settle();
  endtask

  task automatic testReset();
    check("R1 hiz", chanHiZ, 20'hFFFFF);
    check("R1 en", chanEn, 20'h0);
    check("R1 started", started, 0);
    check("R1 addr", addrCode, 0);
  endtask

  task automatic testPrestart();
    pins = 8'hAA; sbSel = 1'b0; settle();
    check("R2 hiz", chanHiZ, 20'hFFFFF);
    check("R2 en", chanEn, 20'h0);
    pins = 8'h00;
  endtask

  task automatic testStart();
    strapHi = 2'b10; strapLo = 2'b01;
    pwrGood = 1'b1; settle();
    check("R3 started", started, 1);
    check("R3 addr", addrCode, 7);
    check("R4 hiz off", chanHiZ, 20'h0);
    check("R7 default all on", chanEn, 20'hFFFFF);
  endtask

  task automatic testRegPins();
    logic [19:0] r = 20'hA5C3F;
    logic [19:0] e;
    writeReg(r); settle();
    check("R7 written", chanEn, r);
    pins = 8'b1010_0110; settle();
    e = expPin(r, pins);
    check("R5 pinned channels", chanEn & 20'h01FE0, e & 20'h01FE0);
    check("R6 free channels", chanEn & 20'hFE01F, r & 20'hFE01F);
    pins = 8'h00;
  endtask

  task automatic testPowerDown();
    pwrGood = 1'b0; settle();
    check("R4 pd hiz", chanHiZ, 20'hFFFFF);
    check("R4 pd en", chanEn, 20'h0);
    check("R3 still started", started, 1);
    strapHi = 2'b00; strapLo = 2'b00;
    pwrGood = 1'b1; settle();
    check("R3 code held", addrCode, 7);
    check("R4 restored", chanEn, 20'hA5C3F);
  endtask

  task automatic testSideBand();
    logic [19:0] w = 20'hC3A51;
    sbSel = 1'b1; settle();
    check("R8 empty out reg", chanEn, 20'h0);
    sbWrite(w);
    check("R9 R10 word loaded", chanEn, w);
    writeReg(20'h0); pins[7] = 1'b1; settle();
    check("R8 pins and reg ignored", chanEn, w);
    pins[7] = 1'b0; settle();
  endtask

  task automatic testCoincide();
    logic [19:0] pre = {20'hC3A51, 4'hF} & 20'hFFFFF;
    pins[5] = 1'b1; settle();
    for (int i = 0; i < 4; i++) sbClockBit(1'b1);
    pins[0] = 1'b0; settle();
    pins[1] = 1'b1; pins[5] = 1'b0; settle();
    pins[1] = 1'b0; settle();
    check("R11 coincident edge", chanEn, pre);
    for (int i = 0; i < 2; i++) sbClockBit(1'b0);
    pins[5] = 1'b1; settle();
    pins[5] = 1'b0; settle();
    check("R10 clocks with load low ignored", chanEn, pre);
  endtask

  task automatic testInactive();
    logic [19:0] held = {20'hC3A51, 4'hF} & 20'hFFFFF;
    sbSel = 1'b0; settle();
    check("R5 pin mode with zero reg", chanEn, 20'h0);
    sbWrite(20'h12345);
    pins = 8'h00;
    sbSel = 1'b1; settle();
    check("R12 side-band inactive in pin mode", chanEn, held);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPrestart();
    testStart();
    testRegPins();
    testPowerDown();
    testSideBand();
    testCoincide();
    testInactive();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule